// File: doc/BRIEF.md
# Countdown Timer with Auto-Reload

This block is a 32-bit down-counter that sits behind one register on a simple register bus. A write loads a start value, and the counter falls by one on every clock until it reaches zero. When it gets there, it raises an expiry event. A parameter decides where that event goes:

- In the standard configuration it leaves as a one-clock interrupt pulse.
- In the watchdog configuration it leaves as a one-clock system reboot request.

The top bit of the written word asks for periodic operation. In that mode the counter reloads the last programmed interval each time it expires, so software gets a steady interrupt every interval. Writing an interval of zero stops the counter. A read returns the live count together with the periodic flag. The watchdog configuration ignores the periodic flag and never drives the interrupt.

Top module: `tick_timer`

## Requirements
- R1: After reset the read value is 0, and neither the interrupt nor the reboot request is asserted.
- R2: A write with a non-zero interval (write bits 30:0) loads that interval into the counter. From the next clock the read value shows it in bits 30:0.
- R3: While the count is above one and no write occurs, the count drops by exactly one per clock.
- R4: A write while the counter is running replaces the count with the new interval, and counting restarts from that value. A write in the same cycle as an expiry takes priority and suppresses that expiry.
- R5: A write whose interval bits are zero leaves the counter at zero. No expiry event follows until a later write with a non-zero interval.
- R6: With the periodic flag clear, a write of interval N produces exactly one expiry pulse, seen N clocks after the write. After it the count stays at 0 with no further pulses.
- R7: With the periodic flag set (write bit 31 = 1), each expiry pulses the interrupt and reloads the count with the last written interval. An interval N gives one pulse every N clocks, the first one N clocks after the write.
- R8: A read returns the periodic flag in bit 31 and the current count in bits 30:0.
- R9: With WATCHDOG = 1, the expiry event drives the reboot request as a one-clock pulse and never drives the interrupt. Write bit 31 is ignored, so bit 31 of a read is 0 and the count never reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data: bit 31 is the periodic flag, bits 30:0 are the interval |
| rdData | output | 32 | Read data: bit 31 is the periodic flag, bits 30:0 are the current count |
| irqPulse | output | 1 | One-clock interrupt pulse on expiry (standard configuration) |
| rebootReq | output | 1 | One-clock reboot request on expiry (watchdog configuration) |

## Verification
The bench builds two copies of the timer side by side from the same write stream:

- one with WATCHDOG = 0, which exposes periodic reloading and the interrupt path;
- one with WATCHDOG = 1, which exposes the reboot path and shows that the periodic flag is masked.

Both copies use the default 32-bit width, so the full 31-bit interval field and the flag position are exercised. Short intervals bring single-tick expiry, back-to-back reloads and writes that collide with expiry within a few clocks.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // Strobes from the control into the datapath, one cycle's worth.
  typedef struct packed {
    logic load;    // take interval and flag from the write data
    logic dec;     // count down by one
    logic reload;  // copy the stored interval back into the count
  } tmr_strobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        countIsOne,
  input  logic        countNonZero,
  input  logic        autoOn,
  output tmr_strobe_t strobe,
  output logic        fireQ
);
  logic expireNow;

  // A write wins over any count activity in the same cycle.
  always_comb begin
    expireNow     = !wrEn && countIsOne;
    strobe.load   = wrEn;
    strobe.reload = expireNow && autoOn;
    strobe.dec    = !wrEn && countNonZero && !strobe.reload;
  end

  // Registered expiry: high during the cycle in which the count has just reached zero.
  always_ff @(posedge clk) begin
    if (!rstN) fireQ <= 1'b0;
    else       fireQ <= expireNow;
  end
endmodule

// File: rtl/tick_timer_dpath.sv
module tick_timer_dpath
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit WATCHDOG = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmr_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              countIsOne,
  output logic              countNonZero,
  output logic              autoOn
);
  localparam int CNT_W = DATA_W - 1;

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] intervalQ;
  logic             autoQ;
  logic             autoReq;

  // The watchdog build can never reload.
  assign autoReq = WATCHDOG ? 1'b0 : wrData[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= '0;
      intervalQ <= '0;
      autoQ     <= 1'b0;
    end else begin
      if (strobe.load) begin
        countQ    <= wrData[CNT_W-1:0];
        intervalQ <= wrData[CNT_W-1:0];
        autoQ     <= autoReq;
      end else if (strobe.reload) begin
        countQ <= intervalQ;
      end else if (strobe.dec) begin
        countQ <= countQ - 1'b1;
      end
    end
  end

  assign countIsOne   = (countQ == CNT_W'(1));
  assign countNonZero = (countQ != '0);
  assign autoOn       = autoQ;
  assign rdData       = {autoQ, countQ};
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit WATCHDOG = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPulse,
  output logic              rebootReq
);
  tmr_strobe_t strobe;
  logic        countIsOne;
  logic        countNonZero;
  logic        autoOn;
  logic        fireQ;

  tick_timer_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .countIsOne   (countIsOne),
    .countNonZero (countNonZero),
    .autoOn       (autoOn),
    .strobe       (strobe),
    .fireQ        (fireQ)
  );

  tick_timer_dpath #(.DATA_W(DATA_W), .WATCHDOG(WATCHDOG)) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .rdData       (rdData),
    .countIsOne   (countIsOne),
    .countNonZero (countNonZero),
    .autoOn       (autoOn)
  );

  // The parameter steers the expiry event to one of the two outputs.
  generate
    if (WATCHDOG) begin : gWatchdog
      assign irqPulse  = 1'b0;
      assign rebootReq = fireQ;
    end else begin : gInterrupt
      assign irqPulse  = fireQ;
      assign rebootReq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int DATA_W   = 32,
  parameter bit WATCHDOG = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irqPulse,
  input logic              rebootReq
);
  logic [DATA_W-2:0] cnt;
  logic              fire;

  assign cnt  = rdData[DATA_W-2:0];
  assign fire = irqPulse || rebootReq;

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (cnt == $past(wrData[DATA_W-2:0])));

  p_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && cnt > 1) |=> (cnt == $past(cnt) - 1'b1) && !fire);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && cnt == 0) |=> (cnt == 0) && !fire);

  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && cnt == 1 && !rdData[DATA_W-1]) |=> (cnt == 0) && fire);

  p_fire_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> $past(!wrEn && cnt == 1));

  p_wd_route_r9: assert property (@(posedge clk) disable iff (!rstN)
    WATCHDOG |-> (!irqPulse && !rdData[DATA_W-1]));
endmodule

bind tick_timer tick_timer_checker #(.DATA_W(DATA_W), .WATCHDOG(WATCHDOG)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .irqPulse  (irqPulse),
  .rebootReq (rebootReq)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataWd;
  logic        irqPulse, rebootReq, irqWd, rebootWd;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phaseTag = "R1";

  always #10 clk = ~clk;

  tick_timer #(.DATA_W(32), .WATCHDOG(1'b0)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqPulse(irqPulse), .rebootReq(rebootReq));

  tick_timer #(.DATA_W(32), .WATCHDOG(1'b1)) uutWd (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdDataWd), .irqPulse(irqWd), .rebootReq(rebootWd));

  // Reference state, one per configuration.
  typedef struct {
    logic [30:0] count;
    logic [30:0] interval;
    logic        auto;
    logic        fire;
  } ref_t;

  ref_t mStd, mWd;

  function automatic ref_t stepRef(ref_t s, logic wr, logic [31:0] d, logic wd);
    ref_t n = s;
    n.fire = 1'b0;
    if (wr) begin
      n.count = d[30:0];
      n.interval = d[30:0];
      n.auto = wd ? 1'b0 : d[31];
    end else if (s.count == 31'd1) begin
      n.fire = 1'b1;
      n.count = s.auto ? s.interval : 31'd0;
    end else if (s.count != 0) begin
      n.count = s.count - 1'b1;
    end
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(phaseTag, "std rdData", rdData, {mStd.auto, mStd.count});
    chk(phaseTag, "std irq", {31'd0, irqPulse}, {31'd0, mStd.fire});
    chk(phaseTag, "std reboot", {31'd0, rebootReq}, 32'd0);
    chk(phaseTag, "wd rdData", rdDataWd, {mWd.auto, mWd.count});
    chk(phaseTag, "wd irq", {31'd0, irqWd}, 32'd0);
    chk(phaseTag, "wd reboot", {31'd0, rebootWd}, {31'd0, mWd.fire});
  endtask

  // Called at a falling edge: compare, drive, advance to the next falling edge.
  task automatic cycle(logic wr, logic [31:0] d);
    compareAll();
    wrEn = wr;
    wrData = d;
    mStd = stepRef(mStd, wr, d, 1'b0);
    mWd = stepRef(mWd, wr, d, 1'b1);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mStd = '{count: '0, interval: '0, auto: 1'b0, fire: 1'b0};
    mWd = mStd;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    phaseTag = "R1";
    chk("R1", "rdData after reset", rdData, 32'd0);
    chk("R1", "irq after reset", {31'd0, irqPulse}, 32'd0);
    chk("R1", "reboot after reset", {31'd0, rebootWd}, 32'd0);

    // R2/R3/R6: one-shot with interval 5
    phaseTag = "R6";
    cycle(1'b1, 32'd5);
    chk("R2", "loaded count", rdData, 32'd5);
    cycle(1'b0, 32'd0);
    chk("R3", "count after one tick", rdData, 32'd4);
    idle(4);
    chk("R6", "one-shot pulse", {31'd0, irqPulse}, 32'd1);
    chk("R6", "count at expiry", rdData, 32'd0);
    chk("R9", "watchdog reboot", {31'd0, rebootWd}, 32'd1);
    chk("R9", "watchdog no irq", {31'd0, irqWd}, 32'd0);
    cycle(1'b0, 32'd0);
    chk("R6", "pulse is single", {31'd0, irqPulse}, 32'd0);
    idle(10);
    chk("R6", "stays at zero", rdData, 32'd0);

    // R7/R8: periodic with interval 3
    phaseTag = "R7";
    cycle(1'b1, 32'h8000_0003);
    chk("R8", "flag and count", rdData, 32'h8000_0003);
    chk("R9", "watchdog flag masked", rdDataWd, 32'h0000_0003);
    idle(3);
    chk("R7", "first periodic pulse", {31'd0, irqPulse}, 32'd1);
    chk("R7", "count reloaded", rdData, 32'h8000_0003);
    chk("R9", "watchdog no reload", rdDataWd, 32'd0);
    idle(3);
    chk("R7", "second periodic pulse", {31'd0, irqPulse}, 32'd1);

    // R7 with interval 1: pulse on every clock
    cycle(1'b1, 32'h8000_0001);
    idle(1);
    chk("R7", "interval one pulse a", {31'd0, irqPulse}, 32'd1);
    idle(1);
    chk("R7", "interval one pulse b", {31'd0, irqPulse}, 32'd1);

    // R4: rewrite while running, including a collision with expiry
    phaseTag = "R4";
    cycle(1'b1, 32'd10);
    idle(4);
    cycle(1'b1, 32'd20);
    chk("R4", "restarted count", rdData, 32'd20);
    cycle(1'b1, 32'd2);
    idle(1);
    cycle(1'b1, 32'd7);
    chk("R4", "write beats expiry irq", {31'd0, irqPulse}, 32'd0);
    chk("R4", "write beats expiry count", rdData, 32'd7);

    // R5: zero interval disables
    phaseTag = "R5";
    cycle(1'b1, 32'd0);
    chk("R5", "disabled count", rdData, 32'd0);
    idle(20);
    chk("R5", "still disabled", rdData, 32'd0);
    chk("R5", "no pulse", {31'd0, irqPulse}, 32'd0);
    cycle(1'b1, 32'h8000_0000);
    idle(5);
    chk("R5", "flag only, no count", rdData, 32'h8000_0000);

    // Large interval: R2/R8 over the full field width
    phaseTag = "R8";
    cycle(1'b1, 32'hFFFF_FFFF);
    chk("R8", "full field", rdData, 32'hFFFF_FFFF);
    cycle(1'b0, 32'd0);
    chk("R3", "full field tick", rdData, 32'hFFFF_FFFE);

    // Constrained random mix
    phaseTag = "R3";
    for (int i = 0; i < 4000; i++) begin
      logic        doWr;
      logic [31:0] d;
      doWr = ($urandom_range(0, 99) < 6);
      d[31] = $urandom_range(0, 1);
      case ($urandom_range(0, 9))
        0:       d[30:0] = 31'd0;
        1:       d[30:0] = 31'd1;
        2:       d[30:0] = $urandom_range(100, 400);
        default: d[30:0] = $urandom_range(2, 25);
      endcase
      cycle(doWr, d);
    end
    compareAll();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule